// File: doc/BRIEF.md
# Register Rename History Buffer

This block keeps, for each hardware thread, an ordered log of destination-register renames. Rename pushes one record per renamed destination at the young end of its thread's log. The record holds the instruction's sequence number, the architectural register, the physical register just assigned and the physical register it displaced. The log serves two purposes: undoing mappings after a misprediction and reclaiming registers at retirement.

A squash request carries a sequence number. The thread's log is then walked from the young end, one record per cycle. For every record younger than that number, the block drives a restore command (architectural register and displaced physical register) to the external map table. In the same cycle it hands the newly assigned register back to the external free list. While the walk runs, the thread reports busy and refuses pushes.

A commit request also carries a sequence number and arms a retirement mark. From the next cycle, records at the old end whose sequence number is at or below the mark are removed at a rate of one per cycle, and the register each one displaced is released. Each thread reports a full flag so that rename stalls before it overruns the log.

Top module: `rename_history_buf`

## Requirements
- R1: A push with push_valid high is steered to the thread given by push_tid. It is stored at that thread's young end when the thread is neither full nor busy. Each thread keeps its own log.
- R2: full_o[t] is high exactly when thread t holds DEPTH records. A push to a full thread is dropped and leaves the log unchanged.
- R3: A squash request for thread t raises busy_o[t] from the next cycle. Each following cycle, while the youngest record has a sequence number greater than the squash number, restore_valid_o[t] is high. At the same time restore_areg_o and restore_preg_o carry that record's architectural register and displaced physical register, and the record is removed. Records are undone youngest first.
- R4: In every cycle that a restore is driven, release_valid_o[t] is high and release_preg_o carries the same record's newly assigned physical register.
- R5: If k records are undone, busy_o[t] stays high for exactly k+1 cycles, and the last of these cycles has no restore. Records whose sequence number is at or below the squash number remain.
- R6: A push to a thread while it is busy is dropped.
- R7: A commit request for thread t arms a mark. From the next cycle, while the oldest record has a sequence number at or below the mark, one record per cycle is removed, and release_valid_o[t] is high with release_preg_o carrying its displaced physical register. Records are removed oldest first.
- R8: While a thread is busy its commit removal pauses and resumes once busy falls. Restore and release never come from two different records in the same cycle.
- R9: Squash, commit and push activity on one thread has no effect on the outputs of another thread.
- R10: After reset every log is empty, the commit mark is unarmed, and full_o, busy_o, restore_valid_o and release_valid_o are all low.
- R11: Sequence numbers are compared as unsigned SEQ_W-bit values without wrap-around. A record whose number equals the squash number is kept, and one whose number equals the commit mark is retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Record push strobe |
| push_tid | input | TID_W | Thread of the pushed record |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Newly assigned physical register |
| push_old_preg | input | PREG_W | Previously mapped physical register |
| squash_valid | input | 1 | Squash request strobe |
| squash_tid | input | TID_W | Thread to squash |
| squash_seq | input | SEQ_W | Youngest sequence number that survives |
| commit_valid | input | 1 | Commit request strobe |
| commit_tid | input | TID_W | Thread that committed |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| full_o | output | NUM_THREADS | Per-thread log full |
| busy_o | output | NUM_THREADS | Per-thread squash walk in progress |
| restore_valid_o | output | NUM_THREADS | Per-thread map restore strobe |
| restore_areg_o | output | NUM_THREADS*AREG_W | Architectural register to restore, per thread |
| restore_preg_o | output | NUM_THREADS*PREG_W | Physical register to map back, per thread |
| release_valid_o | output | NUM_THREADS | Per-thread free-list return strobe |
| release_preg_o | output | NUM_THREADS*PREG_W | Physical register returned, per thread |

## Verification
A corrupt pointer or count inside a thread's log shows at the ports within one walk or drain. A squash then restores the wrong registers or the wrong number of them, and busy holds for a different number of cycles than k+1. A commit to the youngest pushed number releases a different count or sequence of registers than were pushed. A wrong walk or mark state appears the cycle after the request as a missing or extra strobe. Because the sweeps finish every scenario by draining each log to empty through the ports, damage left in storage is exposed before the next scenario begins.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_UNDO = 1'b1
  } walk_e;

endpackage

// File: rtl/rhb_ring.sv
module rhb_ring #(
  parameter int DEPTH = 4,
  parameter int ENT_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [ENT_W-1:0] push_data,
  input  logic             pop_young_en,
  input  logic             pop_old_en,
  output logic [ENT_W-1:0] young_data,
  output logic [ENT_W-1:0] old_data,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, head_n;
  logic [PTR_W-1:0] tail_q, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PTR_W-1:0] young_idx;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - PTR_W'(1);
  endfunction

  always_comb begin
    tail_n = tail_q;
    head_n = head_q;
    if (push_en) begin
      tail_n = ptr_inc(tail_q);
    end else if (pop_young_en) begin
      tail_n = ptr_dec(tail_q);
    end
    if (pop_old_en) begin
      head_n = ptr_inc(head_q);
    end
    cnt_n = cnt_q + CNT_W'(push_en) - CNT_W'(pop_young_en) - CNT_W'(pop_old_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  // storage carries no reset; only slots below the count are ever read
  always_ff @(posedge clk) begin
    if (push_en) begin
      mem[tail_q] <= push_data;
    end
  end

  assign young_idx  = ptr_dec(tail_q);
  assign young_data = mem[young_idx];
  assign old_data   = mem[head_q];
  assign count_o    = cnt_q;
  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CAP);

  p_push_not_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full_o);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);

  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_young_en || pop_old_en) |-> !empty_o);

  p_single_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_young_en && pop_old_en));

endmodule

// File: rtl/rhb_thread.sv
module rhb_thread
  import rhb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 8,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_new_preg,
  input  logic [PREG_W-1:0] push_old_preg,
  input  logic              squash_req,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_req,
  input  logic [SEQ_W-1:0]  commit_seq,
  output logic              full_o,
  output logic              busy_o,
  output logic              restore_valid_o,
  output logic [AREG_W-1:0] restore_areg_o,
  output logic [PREG_W-1:0] restore_preg_o,
  output logic              release_valid_o,
  output logic [PREG_W-1:0] release_preg_o
);

  localparam int ENT_W = SEQ_W + AREG_W + 2 * PREG_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [AREG_W-1:0] areg;
    logic [PREG_W-1:0] new_p;
    logic [PREG_W-1:0] old_p;
  } rec_t;

  rec_t             push_rec, young_rec, old_rec;
  logic [ENT_W-1:0] young_raw, old_raw;
  logic [CNT_W-1:0] count;
  logic             empty, full;

  walk_e            walk_q, walk_n;
  logic [SEQ_W-1:0] sq_seq_q, sq_seq_n;
  logic [SEQ_W-1:0] mark_q, mark_n;
  logic             mark_vld_q, mark_vld_n;

  logic             walking;
  logic             undo_hit;
  logic             retire_hit;
  logic             push_en;

  assign push_rec = '{seq: push_seq, areg: push_areg,
                      new_p: push_new_preg, old_p: push_old_preg};

  rhb_ring #(
    .DEPTH (DEPTH),
    .ENT_W (ENT_W)
  ) ring_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_en      (push_en),
    .push_data    (push_rec),
    .pop_young_en (undo_hit),
    .pop_old_en   (retire_hit),
    .young_data   (young_raw),
    .old_data     (old_raw),
    .count_o      (count),
    .empty_o      (empty),
    .full_o       (full)
  );

  assign young_rec = young_raw;
  assign old_rec   = old_raw;

  assign walking    = (walk_q == WALK_UNDO);
  assign undo_hit   = walking && !empty && (young_rec.seq > sq_seq_q);
  assign retire_hit = !walking && mark_vld_q && !empty && (old_rec.seq <= mark_q);
  assign push_en    = push_req && !full && !walking;

  always_comb begin
    walk_n     = walk_q;
    sq_seq_n   = sq_seq_q;
    mark_n     = mark_q;
    mark_vld_n = mark_vld_q;
    if (squash_req) begin
      walk_n   = WALK_UNDO;
      sq_seq_n = squash_seq;
    end else if (walking && !undo_hit) begin
      walk_n = WALK_IDLE;
    end
    if (commit_req) begin
      mark_n     = commit_seq;
      mark_vld_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_q     <= WALK_IDLE;
      sq_seq_q   <= '0;
      mark_q     <= '0;
      mark_vld_q <= 1'b0;
    end else begin
      walk_q     <= walk_n;
      mark_vld_q <= mark_vld_n;
      if (squash_req) begin
        sq_seq_q <= sq_seq_n;
      end
      if (commit_req) begin
        mark_q <= mark_n;
      end
    end
  end

  assign full_o          = full;
  assign busy_o          = walking;
  assign restore_valid_o = undo_hit;
  assign restore_areg_o  = young_rec.areg;
  assign restore_preg_o  = young_rec.old_p;
  assign release_valid_o = undo_hit || retire_hit;
  assign release_preg_o  = undo_hit ? young_rec.new_p : old_rec.old_p;

  p_squash_starts_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    squash_req |=> busy_o);

  p_undo_shrinks_log_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_hit && !squash_req) |=> (count == $past(count) - CNT_W'(1)));

  p_walk_leaves_older_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (empty || (young_rec.seq <= sq_seq_q)));

  p_busy_refuses_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !undo_hit) |=> (count == $past(count)));

  p_retire_shrinks_log_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_hit |=> (count == $past(count) - CNT_W'(1) + CNT_W'($past(push_en))));

  p_retire_within_mark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (release_valid_o && !restore_valid_o) |-> (old_rec.seq <= mark_q));

endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf #(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 4,
  parameter int SEQ_W       = 8,
  parameter int AREG_W      = 5,
  parameter int PREG_W      = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_valid,
  input  logic [TID_W-1:0]              push_tid,
  input  logic [SEQ_W-1:0]              push_seq,
  input  logic [AREG_W-1:0]             push_areg,
  input  logic [PREG_W-1:0]             push_new_preg,
  input  logic [PREG_W-1:0]             push_old_preg,
  input  logic                          squash_valid,
  input  logic [TID_W-1:0]              squash_tid,
  input  logic [SEQ_W-1:0]              squash_seq,
  input  logic                          commit_valid,
  input  logic [TID_W-1:0]              commit_tid,
  input  logic [SEQ_W-1:0]              commit_seq,
  output logic [NUM_THREADS-1:0]        full_o,
  output logic [NUM_THREADS-1:0]        busy_o,
  output logic [NUM_THREADS-1:0]        restore_valid_o,
  output logic [NUM_THREADS*AREG_W-1:0] restore_areg_o,
  output logic [NUM_THREADS*PREG_W-1:0] restore_preg_o,
  output logic [NUM_THREADS-1:0]        release_valid_o,
  output logic [NUM_THREADS*PREG_W-1:0] release_preg_o
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic push_hit, squash_hit, commit_hit;

    assign push_hit   = push_valid   && (push_tid   == TID_W'(t));
    assign squash_hit = squash_valid && (squash_tid == TID_W'(t));
    assign commit_hit = commit_valid && (commit_tid == TID_W'(t));

    rhb_thread #(
      .DEPTH  (DEPTH),
      .SEQ_W  (SEQ_W),
      .AREG_W (AREG_W),
      .PREG_W (PREG_W)
    ) thread_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .push_req        (push_hit),
      .push_seq        (push_seq),
      .push_areg       (push_areg),
      .push_new_preg   (push_new_preg),
      .push_old_preg   (push_old_preg),
      .squash_req      (squash_hit),
      .squash_seq      (squash_seq),
      .commit_req      (commit_hit),
      .commit_seq      (commit_seq),
      .full_o          (full_o[t]),
      .busy_o          (busy_o[t]),
      .restore_valid_o (restore_valid_o[t]),
      .restore_areg_o  (restore_areg_o[t*AREG_W +: AREG_W]),
      .restore_preg_o  (restore_preg_o[t*PREG_W +: PREG_W]),
      .release_valid_o (release_valid_o[t]),
      .release_preg_o  (release_preg_o[t*PREG_W +: PREG_W])
    );

    p_restore_pairs_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid_o[t] |-> release_valid_o[t]);

    p_restore_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid_o[t] |-> busy_o[t]);
  end

endmodule

// File: tb/rename_history_buf_tb_top.sv
module rename_history_buf_tb_top;

  localparam int NT = 2;
  localparam int DP = 4;
  localparam int SW = 8;
  localparam int AW = 5;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic push_valid, squash_valid, commit_valid;
  logic [0:0] push_tid, squash_tid, commit_tid;
  logic [SW-1:0] push_seq, squash_seq, commit_seq;
  logic [AW-1:0] push_areg;
  logic [PW-1:0] push_new_preg, push_old_preg;
  logic [NT-1:0] full_o, busy_o, restore_valid_o, release_valid_o;
  logic [NT*AW-1:0] restore_areg_o;
  logic [NT*PW-1:0] restore_preg_o, release_preg_o;

  int n_chk = 0;
  int n_fail = 0;
  int g_seq = 10;

  int m_seq [NT][DP];
  int m_ar  [NT][DP];
  int m_np  [NT][DP];
  int m_op  [NT][DP];
  int m_cnt [NT];

  always #10 clk = ~clk;

  rename_history_buf #(
    .NUM_THREADS (NT), .DEPTH (DP), .SEQ_W (SW), .AREG_W (AW), .PREG_W (PW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .push_valid (push_valid), .push_tid (push_tid), .push_seq (push_seq),
    .push_areg (push_areg), .push_new_preg (push_new_preg), .push_old_preg (push_old_preg),
    .squash_valid (squash_valid), .squash_tid (squash_tid), .squash_seq (squash_seq),
    .commit_valid (commit_valid), .commit_tid (commit_tid), .commit_seq (commit_seq),
    .full_o (full_o), .busy_o (busy_o), .restore_valid_o (restore_valid_o),
    .restore_areg_o (restore_areg_o), .restore_preg_o (restore_preg_o),
    .release_valid_o (release_valid_o), .release_preg_o (release_preg_o)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int r_areg(input int t);
    return int'(restore_areg_o[t*AW +: AW]);
  endfunction
  function automatic int r_preg(input int t);
    return int'(restore_preg_o[t*PW +: PW]);
  endfunction
  function automatic int f_preg(input int t);
    return int'(release_preg_o[t*PW +: PW]);
  endfunction

  task automatic pop_front(input int t);
    for (int i = 0; i < DP - 1; i++) begin
      m_seq[t][i] = m_seq[t][i+1];
      m_ar[t][i]  = m_ar[t][i+1];
      m_np[t][i]  = m_np[t][i+1];
      m_op[t][i]  = m_op[t][i+1];
    end
    m_cnt[t]--;
  endtask

  // one push attempt; model stores it only when the thread has room (R1, R2)
  task automatic push1(input int t, input int ar, input int np, input int op);
    @(negedge clk);
    push_valid = 1'b1; push_tid = 1'(t); push_seq = SW'(g_seq);
    push_areg = AW'(ar); push_new_preg = PW'(np); push_old_preg = PW'(op);
    if (m_cnt[t] < DP) begin
      m_seq[t][m_cnt[t]] = g_seq; m_ar[t][m_cnt[t]] = ar;
      m_np[t][m_cnt[t]] = np;     m_op[t][m_cnt[t]] = op;
      m_cnt[t]++;
    end
    g_seq++;
    @(posedge clk); #1;
    push_valid = 1'b0;
  endtask

  task automatic squash1(input int t, input int sseq);
    int k;
    @(negedge clk);
    squash_valid = 1'b1; squash_tid = 1'(t); squash_seq = SW'(sseq);
    @(posedge clk); #1;
    squash_valid = 1'b0;
    k = 0;
    for (int i = m_cnt[t] - 1; i >= 0; i--) if (m_seq[t][i] > sseq) k++; else break;
    for (int i = 0; i < k; i++) begin
      int y;
      y = m_cnt[t] - 1;
      @(negedge clk);
      chk("R5", "busy in walk", int'(busy_o[t]), 1);
      chk("R3", "restore strobe", int'(restore_valid_o[t]), 1);
      chk("R3", "restore areg", r_areg(t), m_ar[t][y]);
      chk("R3", "restore preg", r_preg(t), m_op[t][y]);
      chk("R4", "release strobe", int'(release_valid_o[t]), 1);
      chk("R4", "release new preg", f_preg(t), m_np[t][y]);
      chk("R9", "other thread restore", int'(restore_valid_o[1-t]), 0);
      chk("R9", "other thread release", int'(release_valid_o[1-t]), 0);
      m_cnt[t]--;
    end
    @(negedge clk);
    chk("R5", "busy tail cycle", int'(busy_o[t]), 1);
    chk("R5", "no restore tail", int'(restore_valid_o[t]), 0);
    @(negedge clk);
    chk("R5", "busy dropped", int'(busy_o[t]), 0);
    chk("R5", "no release after walk", int'(release_valid_o[t]), 0);
  endtask

  task automatic commit1(input int t, input int cseq);
    int k;
    @(negedge clk);
    commit_valid = 1'b1; commit_tid = 1'(t); commit_seq = SW'(cseq);
    @(posedge clk); #1;
    commit_valid = 1'b0;
    k = 0;
    for (int i = 0; i < m_cnt[t]; i++) if (m_seq[t][i] <= cseq) k++; else break;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk("R7", "retire strobe", int'(release_valid_o[t]), 1);
      chk("R7", "retire old preg", f_preg(t), m_op[t][0]);
      chk("R7", "no restore on retire", int'(restore_valid_o[t]), 0);
      pop_front(t);
    end
    @(negedge clk);
    chk("R7", "retire stops", int'(release_valid_o[t]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int sseq, e0, ea, eb, ec;
    push_valid = 0; squash_valid = 0; commit_valid = 0;
    push_tid = 0; squash_tid = 0; commit_tid = 0;
    push_seq = 0; squash_seq = 0; commit_seq = 0;
    push_areg = 0; push_new_preg = 0; push_old_preg = 0;
    m_cnt[0] = 0; m_cnt[1] = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    chk("R10", "full", int'(full_o), 0);
    chk("R10", "busy", int'(busy_o), 0);
    chk("R10", "restore", int'(restore_valid_o), 0);
    chk("R10", "release", int'(release_valid_o), 0);

    // sweep: every thread, every fill level, every squash cut point (R1 R3 R5 R11)
    for (int t = 0; t < NT; t++) begin
      for (int n = 0; n <= DP; n++) begin
        for (int j = 0; j <= n; j++) begin
          for (int i = 0; i < n; i++)
            push1(t, (t*7 + i*3 + n) % 32, (i*5 + j + t*11 + 1) % 64, (i*9 + n + 17) % 64);
          @(negedge clk);
          chk("R2", "full flag after fill", int'(full_o[t]), (n == DP) ? 1 : 0);
          chk("R1", "other thread empty-full", int'(full_o[1-t]), 0);
          if (j > 0) sseq = m_seq[t][j-1];
          else if (n > 0) sseq = m_seq[t][0] - 1;
          else sseq = g_seq - 1;
          squash1(t, sseq);
          chk("R11", "kept count", m_cnt[t], j);
          if (m_cnt[t] > 0) commit1(t, m_seq[t][m_cnt[t]-1]);
        end
      end
    end

    // R2: fifth push to a full thread is dropped
    for (int i = 0; i < DP + 1; i++) push1(0, i + 1, i + 40, i + 20);
    @(negedge clk);
    chk("R2", "full after overflow", int'(full_o[0]), 1);
    commit1(0, g_seq - 1);
    chk("R2", "model drained", m_cnt[0], 0);

    // R6: push during walk is refused
    push1(1, 3, 30, 31);
    push1(1, 4, 32, 33);
    e0 = m_seq[1][0];
    @(negedge clk);
    squash_valid = 1'b1; squash_tid = 1'b1; squash_seq = SW'(e0);
    @(posedge clk); #1;
    squash_valid = 1'b0;
    push_valid = 1'b1; push_tid = 1'b1; push_seq = SW'(g_seq);
    push_areg = 5'd9; push_new_preg = 6'd50; push_old_preg = 6'd51;
    g_seq++;
    @(posedge clk); #1;
    push_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6", "busy over", int'(busy_o[1]), 0);
    m_cnt[1] = 1;
    commit1(1, g_seq - 1);
    chk("R6", "only survivor retired", m_cnt[1], 0);

    // R8: squash and commit in the same cycle
    push1(0, 1, 11, 21);
    push1(0, 2, 12, 22);
    push1(0, 3, 13, 23);
    ea = m_seq[0][0]; eb = m_seq[0][1]; ec = m_seq[0][2];
    @(negedge clk);
    squash_valid = 1'b1; squash_tid = 1'b0; squash_seq = SW'(eb);
    commit_valid = 1'b1; commit_tid = 1'b0; commit_seq = SW'(ea);
    @(posedge clk); #1;
    squash_valid = 1'b0; commit_valid = 1'b0;
    @(negedge clk);
    chk("R8", "undo youngest", r_preg(0), 23);
    chk("R8", "release is new preg", f_preg(0), 13);
    @(negedge clk);
    chk("R8", "no retire while busy", int'(release_valid_o[0]), 0);
    chk("R8", "still busy", int'(busy_o[0]), 1);
    @(negedge clk);
    chk("R8", "retire after walk", int'(release_valid_o[0]), 1);
    chk("R8", "retired old preg", f_preg(0), 21);
    @(negedge clk);
    chk("R8", "single retire", int'(release_valid_o[0]), 0);
    m_cnt[0] = 1; m_seq[0][0] = eb; m_op[0][0] = 22; m_ar[0][0] = 2; m_np[0][0] = 12;
    if (ec < 0) chk("R8", "seq order", ec, 0);
    commit1(0, eb);

    // R9: commit on thread 0 while thread 1 walks
    push1(0, 5, 41, 42);
    push1(0, 6, 43, 44);
    push1(1, 7, 45, 46);
    push1(1, 8, 47, 48);
    @(negedge clk);
    commit_valid = 1'b1; commit_tid = 1'b0; commit_seq = SW'(g_seq - 1);
    squash_valid = 1'b1; squash_tid = 1'b1; squash_seq = SW'(m_seq[1][0] - 1);
    @(posedge clk); #1;
    commit_valid = 1'b0; squash_valid = 1'b0;
    @(negedge clk);
    chk("R9", "t0 retire first", f_preg(0), 42);
    chk("R9", "t1 undo young", r_preg(1), 48);
    chk("R9", "t0 not busy", int'(busy_o[0]), 0);
    @(negedge clk);
    chk("R9", "t0 retire second", f_preg(0), 44);
    chk("R9", "t1 undo old", r_preg(1), 46);
    @(negedge clk);
    chk("R9", "t0 idle", int'(release_valid_o[0]), 0);
    chk("R9", "t1 tail busy", int'(busy_o[1]), 1);
    @(negedge clk);
    chk("R9", "t1 done", int'(busy_o[1]), 0);
    chk("R9", "t1 quiet", int'(release_valid_o[1]), 0);

    summary();
    $finish;
  end

endmodule